// File: doc/BRIEF.md
# Boost PFC Protection Supervisor

This block supervises a boost power-factor stage from digitised sense values. On each sample strobe it takes four signed millivolt codes (auxiliary supply, output feedback, line brown-out sense and inductor current sense) and compares them with fixed thresholds. It then moves a four-state sequencer between off, standby, start-up and normal operation.

From that state and the same sample it drives a set of registered control flags. These are a run enable for the PWM core, a hold-down for the voltage compensation node, a force-high for the current compensation node, a soft over-voltage duty reduction request, a hard gate kill, a soft over-current flag and a start-up level-shift flag. Supply lockout and brown-out each use their own hysteresis window. The output feedback has an open-loop floor, a start-up completion level and a two-step over-voltage response.

Top module: `pfc_supervisor`

## Requirements
- R1: After reset every output is 0, the sequencer is off, and both the supply-lockout fault and the brown-out fault are set.
- R2: From off or standby, a strobe with supply > 11800 mV, brown-out sense > 1500 mV and feedback > 600 mV enters start-up. In start-up run_en_o=1 and the hold and force outputs are 0.
- R3: The supply-lockout fault sets on a strobe with supply < 11000 mV and clears only on a strobe with supply > 11800 mV. A supply in between keeps the previous fault value, so a running supervisor keeps running and an off supervisor stays off.
- R4: The brown-out fault sets on a strobe with sense < 710 mV and clears only on a strobe with sense > 1500 mV. With the lockout clear and the brown-out fault set, the state is standby: run_en_o=0, vcomp_hold_o=1, icomp_force_o=1.
- R5: Feedback at or below 600 mV is an open-loop fault. Without a lockout fault it forces standby on that strobe.
- R6: A lockout fault outranks all others. The state goes to off and every output is 0, even while brown-out or open-loop faults are present.
- R7: In start-up, boost_shift_o=1 while feedback < 2850 mV. A strobe in start-up with feedback >= 2850 mV moves to normal. Normal does not return to start-up, and boost_shift_o is 0 there.
- R8: While running, duty_cut_o=1 when 3150 < feedback <= 3250 mV, and 0 otherwise.
- R9: While running, gate_kill_o=1 when feedback > 3250 mV, and duty_cut_o is then 0.
- R10: While running, soc_flag_o=1 when current sense < -750 mV. It has no effect on gate_kill_o.
- R11: Outputs change only on the clock edge that samples smp_valid_i=1, and they reflect that sample after that edge. Without a strobe, every output holds.
- R12: In off and standby, duty_cut_o, gate_kill_o, soc_flag_o and boost_shift_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Sample strobe |
| supply_mv_i | input | MV_W | Supply voltage, signed mV |
| fb_mv_i | input | MV_W | Output feedback voltage, signed mV |
| bo_mv_i | input | MV_W | Brown-out sense voltage, signed mV |
| isense_mv_i | input | MV_W | Current-sense voltage, signed mV |
| run_en_o | output | 1 | PWM core enable |
| vcomp_hold_o | output | 1 | Pull voltage compensation node low |
| icomp_force_o | output | 1 | Force current compensation node high |
| duty_cut_o | output | 1 | Soft over-voltage duty reduction |
| gate_kill_o | output | 1 | Hard over-voltage gate off |
| soc_flag_o | output | 1 | Soft over-current flag |
| boost_shift_o | output | 1 | Start-up compensation level shift |

## Verification
The bench uses the default millivolt thresholds and a 16-bit code width, so the negative current-sense codes and every threshold fit with plenty of range to spare. The random values cluster within 20 mV of each threshold. This hits exact equality at 600, 2850, 3250, -750 and the hysteresis edges. It also reaches sequences where a value sits inside a hysteresis band after the window was entered from either side.

// File: rtl/pfc_sup_pkg.sv
package pfc_sup_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_STBY  = 2'd1,
    ST_START = 2'd2,
    ST_NORM  = 2'd3
  } sup_state_e;
endpackage

// File: rtl/pfc_hyst.sv
module pfc_hyst #(
  parameter int MV_W         = 16,
  parameter int SET_BELOW_MV = 710,
  parameter int CLR_ABOVE_MV = 1500
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic signed [MV_W-1:0] val_i,
  output logic                   flag_n_o,
  output logic                   flag_o
);
  localparam logic signed [MV_W-1:0] SET_C = MV_W'(SET_BELOW_MV);
  localparam logic signed [MV_W-1:0] CLR_C = MV_W'(CLR_ABOVE_MV);

  always_comb begin
    flag_n_o = flag_o;
    if (val_i < SET_C)      flag_n_o = 1'b1;
    else if (val_i > CLR_C) flag_n_o = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_o <= 1'b1;
    else if (valid_i) flag_o <= flag_n_o;
  end
endmodule

// File: rtl/pfc_seq_fsm.sv
module pfc_seq_fsm
  import pfc_sup_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic       uvlo_i,
  input  logic       bo_i,
  input  logic       olp_i,
  input  logic       fb_ok_i,
  output sup_state_e state_n_o
);
  sup_state_e state_q;

  always_comb begin
    state_n_o = state_q;
    if (uvlo_i)              state_n_o = ST_OFF;
    else if (bo_i || olp_i)  state_n_o = ST_STBY;
    else begin
      unique case (state_q)
        ST_OFF, ST_STBY: state_n_o = ST_START;
        ST_START:        state_n_o = fb_ok_i ? ST_NORM : ST_START;
        default:         state_n_o = ST_NORM;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      state_q <= ST_OFF;
    else if (valid_i) state_q <= state_n_o;
  end
endmodule

// File: rtl/pfc_supervisor.sv
module pfc_supervisor
  import pfc_sup_pkg::*;
#(
  parameter int MV_W        = 16,
  parameter int VCC_ON_MV   = 11800,
  parameter int VCC_OFF_MV  = 11000,
  parameter int BO_ON_MV    = 1500,
  parameter int BO_OFF_MV   = 710,
  parameter int OLP_MV      = 600,
  parameter int WIN_LO_MV   = 2850,
  parameter int OV_SOFT_MV  = 3150,
  parameter int OV_HARD_MV  = 3250,
  parameter int SOC_MV      = -750
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   smp_valid_i,
  input  logic signed [MV_W-1:0] supply_mv_i,
  input  logic signed [MV_W-1:0] fb_mv_i,
  input  logic signed [MV_W-1:0] bo_mv_i,
  input  logic signed [MV_W-1:0] isense_mv_i,
  output logic                   run_en_o,
  output logic                   vcomp_hold_o,
  output logic                   icomp_force_o,
  output logic                   duty_cut_o,
  output logic                   gate_kill_o,
  output logic                   soc_flag_o,
  output logic                   boost_shift_o
);
  localparam logic signed [MV_W-1:0] OLP_C     = MV_W'(OLP_MV);
  localparam logic signed [MV_W-1:0] WIN_LO_C  = MV_W'(WIN_LO_MV);
  localparam logic signed [MV_W-1:0] OV_SOFT_C = MV_W'(OV_SOFT_MV);
  localparam logic signed [MV_W-1:0] OV_HARD_C = MV_W'(OV_HARD_MV);
  localparam logic signed [MV_W-1:0] SOC_C     = MV_W'(SOC_MV);

  logic       uvlo_n, uvlo_q, bo_n, bo_q, olp, fb_ok, running;
  sup_state_e state_n;

  pfc_hyst #(.MV_W(MV_W), .SET_BELOW_MV(VCC_OFF_MV), .CLR_ABOVE_MV(VCC_ON_MV)) u_uvlo (
    .clk_i, .rst_ni, .valid_i(smp_valid_i), .val_i(supply_mv_i),
    .flag_n_o(uvlo_n), .flag_o(uvlo_q)
  );

  pfc_hyst #(.MV_W(MV_W), .SET_BELOW_MV(BO_OFF_MV), .CLR_ABOVE_MV(BO_ON_MV)) u_bo (
    .clk_i, .rst_ni, .valid_i(smp_valid_i), .val_i(bo_mv_i),
    .flag_n_o(bo_n), .flag_o(bo_q)
  );

  assign olp   = (fb_mv_i <= OLP_C);
  assign fb_ok = (fb_mv_i >= WIN_LO_C);

  pfc_seq_fsm u_fsm (
    .clk_i, .rst_ni, .valid_i(smp_valid_i),
    .uvlo_i(uvlo_n), .bo_i(bo_n), .olp_i(olp), .fb_ok_i(fb_ok),
    .state_n_o(state_n)
  );

  assign running = (state_n == ST_START) || (state_n == ST_NORM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_en_o      <= 1'b0;
      vcomp_hold_o  <= 1'b0;
      icomp_force_o <= 1'b0;
      duty_cut_o    <= 1'b0;
      gate_kill_o   <= 1'b0;
      soc_flag_o    <= 1'b0;
      boost_shift_o <= 1'b0;
    end else if (smp_valid_i) begin
      run_en_o      <= running;
      vcomp_hold_o  <= (state_n == ST_STBY);
      icomp_force_o <= (state_n == ST_STBY);
      // hard level wins over the soft reduction
      gate_kill_o   <= running && (fb_mv_i > OV_HARD_C);
      duty_cut_o    <= running && (fb_mv_i > OV_SOFT_C) && !(fb_mv_i > OV_HARD_C);
      soc_flag_o    <= running && (isense_mv_i < SOC_C);
      boost_shift_o <= (state_n == ST_START) && !fb_ok;
    end
  end

  logic unused_q;
  assign unused_q = uvlo_q ^ bo_q;
endmodule

// File: rtl/pfc_supervisor_chk.sv
module pfc_supervisor_chk #(
  parameter int MV_W       = 16,
  parameter int VCC_OFF_MV = 11000,
  parameter int OLP_MV     = 600,
  parameter int OV_HARD_MV = 3250,
  parameter int SOC_MV     = -750
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   smp_valid_i,
  input logic signed [MV_W-1:0] supply_mv_i,
  input logic signed [MV_W-1:0] fb_mv_i,
  input logic signed [MV_W-1:0] isense_mv_i,
  input logic                   run_en_o,
  input logic                   vcomp_hold_o,
  input logic                   icomp_force_o,
  input logic                   duty_cut_o,
  input logic                   gate_kill_o,
  input logic                   soc_flag_o,
  input logic                   boost_shift_o
);
  localparam logic signed [MV_W-1:0] VOFF_C = MV_W'(VCC_OFF_MV);
  localparam logic signed [MV_W-1:0] OLP_C  = MV_W'(OLP_MV);
  localparam logic signed [MV_W-1:0] HARD_C = MV_W'(OV_HARD_MV);
  localparam logic signed [MV_W-1:0] SOC_C  = MV_W'(SOC_MV);

  a_r11_hold_without_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> $stable({run_en_o, vcomp_hold_o, icomp_force_o, duty_cut_o,
                              gate_kill_o, soc_flag_o, boost_shift_o}));

  a_r6_lockout_all_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i && (supply_mv_i < VOFF_C) |=>
      !run_en_o && !vcomp_hold_o && !icomp_force_o && !gate_kill_o && !soc_flag_o);

  a_r5_open_loop_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i && (fb_mv_i <= OLP_C) |=> !run_en_o && !boost_shift_o);

  a_r9_kill_over_cut: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i && (fb_mv_i > HARD_C) |=> !duty_cut_o);

  a_r10_soc_keeps_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i && (isense_mv_i < SOC_C) && (fb_mv_i <= HARD_C) |=> !gate_kill_o);

  a_r12_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_en_o |-> !duty_cut_o && !gate_kill_o && !soc_flag_o && !boost_shift_o);
endmodule

bind pfc_supervisor pfc_supervisor_chk #(
  .MV_W(MV_W), .VCC_OFF_MV(VCC_OFF_MV), .OLP_MV(OLP_MV),
  .OV_HARD_MV(OV_HARD_MV), .SOC_MV(SOC_MV)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .smp_valid_i(smp_valid_i),
  .supply_mv_i(supply_mv_i), .fb_mv_i(fb_mv_i), .isense_mv_i(isense_mv_i),
  .run_en_o(run_en_o), .vcomp_hold_o(vcomp_hold_o), .icomp_force_o(icomp_force_o),
  .duty_cut_o(duty_cut_o), .gate_kill_o(gate_kill_o), .soc_flag_o(soc_flag_o),
  .boost_shift_o(boost_shift_o)
);

// File: tb/sim_pfc_supervisor.sv
`timescale 1ns/1ps
module sim_pfc_supervisor;
  logic clk = 1'b0, rst_ni = 1'b0, vld = 1'b0;
  logic signed [15:0] sup = '0, fb = '0, bo = '0, isn = '0;
  logic run, hold, force_hi, cut, kill, soc, bst;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference model state: 0 off, 1 standby, 2 start-up, 3 normal
  int m_st = 0;
  bit m_uv = 1'b1, m_bo = 1'b1;
  bit e_run, e_hold, e_force, e_cut, e_kill, e_soc, e_bst;

  always #2 clk = ~clk;

  pfc_supervisor u0 (
    .clk_i(clk), .rst_ni(rst_ni), .smp_valid_i(vld),
    .supply_mv_i(sup), .fb_mv_i(fb), .bo_mv_i(bo), .isense_mv_i(isn),
    .run_en_o(run), .vcomp_hold_o(hold), .icomp_force_o(force_hi),
    .duty_cut_o(cut), .gate_kill_o(kill), .soc_flag_o(soc), .boost_shift_o(bst)
  );

  task automatic model(input int s, input int f, input int b, input int i);
    bit olp;
    if (s < 11000) m_uv = 1'b1; else if (s > 11800) m_uv = 1'b0;
    if (b < 710) m_bo = 1'b1; else if (b > 1500) m_bo = 1'b0;
    olp = (f <= 600);
    if (m_uv) m_st = 0;
    else if (m_bo || olp) m_st = 1;
    else if (m_st < 2) m_st = 2;
    else if (m_st == 2 && f >= 2850) m_st = 3;
    e_run   = (m_st >= 2);
    e_hold  = (m_st == 1);
    e_force = (m_st == 1);
    e_kill  = e_run && (f > 3250);
    e_cut   = e_run && (f > 3150) && (f <= 3250);
    e_soc   = e_run && (i < -750);
    e_bst   = (m_st == 2) && (f < 2850);
  endtask

  task automatic chk(input string req, input string nm, input bit got, input bit exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got=%0d exp=%0d", req, nm, got, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, "run_en",      run,      e_run);
    chk(req, "vcomp_hold",  hold,     e_hold);
    chk(req, "icomp_force", force_hi, e_force);
    chk(req, "duty_cut",    cut,      e_cut);
    chk(req, "gate_kill",   kill,     e_kill);
    chk(req, "soc_flag",    soc,      e_soc);
    chk(req, "boost_shift", bst,      e_bst);
  endtask

  task automatic step(input string req, input int s, input int f, input int b, input int i);
    sup = 16'(s); fb = 16'(f); bo = 16'(b); isn = 16'(i); vld = 1'b1;
    model(s, f, b, i);
    @(negedge clk);
    vld = 1'b0;
    chk_all(req);
  endtask

  task automatic idle(input string req, input int s, input int f, input int b, input int i);
    sup = 16'(s); fb = 16'(f); bo = 16'(b); isn = 16'(i); vld = 1'b0;
    @(negedge clk);
    chk_all(req);
  endtask

  function automatic int near(input int t0, input int t1, input int t2, input int t3,
                              input int lo, input int hi);
    int r, base;
    r = int'($urandom_range(0, 4));
    case (r)
      0: base = t0;
      1: base = t1;
      2: base = t2;
      3: base = t3;
      default: return lo + int'($urandom_range(0, 32'(hi - lo)));
    endcase
    return base + int'($urandom_range(0, 40)) - 20;
  endfunction

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk);
    e_run = 0; e_hold = 0; e_force = 0; e_cut = 0; e_kill = 0; e_soc = 0; e_bst = 0;
    chk_all("R1");
    rst_ni = 1'b1;
    @(negedge clk);
    chk_all("R1");
    step("R3", 11500, 3000, 2000, 0);    // supply in band, lockout stays set
    step("R4", 12000, 3000, 1000, 0);    // brown-out still set in band
    step("R5", 12000, 600, 2000, 0);     // open loop at exactly 600
    step("R2 R7", 12000, 1000, 2000, 0); // start-up with shift
    idle("R11", 9000, 4000, 100, -2000);
    idle("R11", 9000, 4000, 100, -2000);
    step("R7", 12000, 2849, 2000, 0);
    step("R7", 12000, 2850, 2000, 0);    // to normal
    step("R7", 12000, 2000, 2000, 0);    // stays normal
    step("R8", 12000, 3200, 2000, 0);
    step("R9", 12000, 3251, 2000, 0);
    step("R8", 12000, 3250, 2000, 0);
    step("R10", 12000, 3000, 2000, -751);
    step("R10", 12000, 3300, 2000, -900);
    step("R10", 12000, 3000, 2000, -750);
    step("R3", 11200, 3000, 2000, 0);    // running survives band
    step("R4", 11200, 3000, 1000, 0);    // running survives band
    step("R4", 11200, 3000, 700, 0);     // brown-out -> standby
    step("R12", 11200, 3400, 1000, -900);
    step("R2", 11200, 3000, 1600, 0);
    step("R6", 10999, 100, 500, -900);
    step("R12", 11800, 3400, 2000, -900);

    for (int n = 0; n < 4000; n++) begin
      int s, f, b, i;
      s = near(11000, 11800, 11000, 11800, 10000, 13000);
      f = near(600, 2850, 3150, 3250, 0, 4000);
      b = near(710, 1500, 710, 1500, 0, 3000);
      i = near(-750, -750, -750, -750, -1500, 500);
      if ($urandom_range(0, 3) == 0) idle("R11", s, f, b, i);
      else step("R2 R3 R4 R5 R6 R7 R8 R9 R10 R12", s, f, b, i);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule